// File: doc/BRIEF.md
# Graphics Engine Interrupt Controller

This block collects the interrupt causes of a graphics engine's tiling front end and presents them to the host on one interrupt line. Three causes are tracked: the binner has run out of overflow memory, a binning flush has completed, and a render frame has completed. Each cause has a pending bit in a status register. Software clears a pending bit by writing a 1 to it. An enable mask decides which pending bits may raise the interrupt line. The mask is changed through two write addresses, one that sets bits and one that clears them. Reading either address returns the mask.

The two completion causes are pulses from the engine and are latched. The out-of-memory cause is a level. It comes from a starvation flag inside the block. The flag is raised at reset and whenever the binner reports that it has used up the pool it was given. Software feeds the binner by writing a pool base address and then a non-zero pool size. Only that sequence lowers the flag. While the flag is up, the out-of-memory bit comes back on the cycle after software clears it.

The host reaches the block over a simple single-cycle register bus. That bus has a write strobe, a read strobe, a word address and a data bus. Read data is combinational and is zero when no read is requested.

Top module: `gfx_irq_ctrl`

## Requirements
- R1: The status register at address 0 holds out-of-memory in bit 0, flush done in bit 1 and frame done in bit 2, with bits above 2 reading 0. Writing a 1 to a bit clears it on that clock edge. Writing a 0 to a bit leaves it unchanged.
- R2: Writing address 1 sets each enable-mask bit whose data bit is 1. Bits written as 0 keep their value.
- R3: Writing address 2 clears each enable-mask bit whose data bit is 1. Bits written as 0 keep their value.
- R4: A read of address 1 returns the enable mask, and so does a read of address 2.
- R5: Once cleared, a flush-done or frame-done bit stays 0 until its event input pulses again.
- R6: While the binner is starved, status bit 0 is set again on the edge after any clear.
- R7: The pool base is written at address 3 and the pool size at address 4. A size write clears starvation only if it is non-zero and a base write has come since the last size write or spent pulse. A `pool_spent_i` pulse makes the binner starved again and cancels any pending base write. `pool_ok_o` is high exactly when the binner is not starved.
- R8: `irq_o` is a register. It is high one cycle after a cycle in which some status bit and its enable bit are both 1.
- R9: Status bits record events whether or not their enable bit is set.
- R10: If an event and a write-1-to-clear reach the same latched bit on the same edge, the bit stays 1.
- R11: Reset clears status, mask, pool base and pool size, and makes the binner starved. Status bit 0 is therefore set on the first edge after reset.
- R12: A read of addresses 5 to 7 returns 0. `rdata_o` is 0 whenever `rd_en_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data (combinational) |
| flush_done_i | input | 1 | One-cycle pulse: binning flush completed |
| frame_done_i | input | 1 | One-cycle pulse: render frame completed |
| pool_spent_i | input | 1 | One-cycle pulse: binner used up its overflow pool |
| pool_base_o | output | 32 | Overflow pool base address to the binner |
| pool_size_o | output | 32 | Overflow pool size to the binner |
| pool_ok_o | output | 1 | Binner holds a usable overflow pool |
| irq_o | output | 1 | Interrupt line to the host |

## Verification
The bench aims at the cases where level and latched sources behave differently under the same clear.

- Clearing out-of-memory while starved must leave the bit set again one edge later. A design that treats it as latched would lose the interrupt.
- An event that lands on the same edge as a clear must survive. A design that gives the clear priority would drop a frame completion.
- The pool sequence is tried as a size with no base, a zero size after a base, and a spent pulse after a fill. A design that lowers starvation on the wrong write would let the binner run with no memory.
- Masked events must still appear in status. The interrupt line is checked for its one-cycle lag behind status and mask.

// File: rtl/gfx_irq_pkg.sv
package gfx_irq_pkg;
  localparam int NSRC   = 3;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;

  localparam logic [ADDR_W-1:0] ADR_STATUS    = 3'd0;
  localparam logic [ADDR_W-1:0] ADR_EN_SET    = 3'd1;
  localparam logic [ADDR_W-1:0] ADR_EN_CLR    = 3'd2;
  localparam logic [ADDR_W-1:0] ADR_POOL_BASE = 3'd3;
  localparam logic [ADDR_W-1:0] ADR_POOL_SIZE = 3'd4;

  typedef enum int {
    SRC_OOM   = 0,
    SRC_FLUSH = 1,
    SRC_FRAME = 2
  } src_e;
endpackage

// File: rtl/gfx_irq_status.sv
module gfx_irq_status #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic q;
    // set beats clear when both arrive together
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= 1'b0;
      else         q <= set_i[i] | (q & ~clr_i[i]);
    end
    assign stat_o[i] = q;

    assert_evt_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set_i[i] |=> stat_o[i]);
    assert_stays_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stat_o[i] && !set_i[i]) |=> !stat_o[i]);
    assert_w1c_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_o[i] && clr_i[i] && !set_i[i]) |=> !stat_o[i]);
  end
endmodule

// File: rtl/gfx_irq_mask.sv
module gfx_irq_mask #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] mask_o
);
  logic [N-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= (mask_q | set_i) & ~clr_i;
  end
  assign mask_o = mask_q;

  for (genvar i = 0; i < N; i++) begin : g_chk
    assert_set_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i[i] && !clr_i[i]) |=> mask_o[i]);
    assert_clr_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i[i] |=> !mask_o[i]);
    assert_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!set_i[i] && !clr_i[i]) |=> $stable(mask_o[i]));
  end
endmodule

// File: rtl/gfx_irq_pool.sv
module gfx_irq_pool #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_base_i,
  input  logic         wr_size_i,
  input  logic [W-1:0] wdata_i,
  input  logic         spent_i,
  output logic [W-1:0] base_o,
  output logic [W-1:0] size_o,
  output logic         starved_o
);
  logic [W-1:0] base_q, size_q;
  logic         armed_q, starved_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q    <= '0;
      size_q    <= '0;
      armed_q   <= 1'b0;
      starved_q <= 1'b1;
    end else begin
      if (wr_base_i) begin
        base_q  <= wdata_i;
        armed_q <= 1'b1;
      end
      if (wr_size_i) begin
        size_q  <= wdata_i;
        armed_q <= 1'b0;
        if (armed_q && (wdata_i != '0)) starved_q <= 1'b0;
      end
      // spent pulse overrides any fill on the same edge
      if (spent_i) begin
        armed_q   <= 1'b0;
        starved_q <= 1'b1;
      end
    end
  end

  assign base_o    = base_q;
  assign size_o    = size_q;
  assign starved_o = starved_q;

  assert_fill_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_size_i && armed_q && (wdata_i != '0) && !spent_i) |=> !starved_o);
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (starved_o && !wr_size_i) |=> starved_o);
  assert_spent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spent_i |=> starved_o);
endmodule

// File: rtl/gfx_irq_ctrl.sv
module gfx_irq_ctrl
  import gfx_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              flush_done_i,
  input  logic              frame_done_i,
  input  logic              pool_spent_i,
  output logic [DATA_W-1:0] pool_base_o,
  output logic [DATA_W-1:0] pool_size_o,
  output logic              pool_ok_o,
  output logic              irq_o
);
  localparam int PAD_W = DATA_W - NSRC;

  logic [NSRC-1:0] stat, mask, stat_set, stat_clr, en_set, en_clr;
  logic            starved, irq_q;
  logic            wr_stat, wr_set, wr_clr, wr_base, wr_size;

  assign wr_stat = wr_en_i && (addr_i == ADR_STATUS);
  assign wr_set  = wr_en_i && (addr_i == ADR_EN_SET);
  assign wr_clr  = wr_en_i && (addr_i == ADR_EN_CLR);
  assign wr_base = wr_en_i && (addr_i == ADR_POOL_BASE);
  assign wr_size = wr_en_i && (addr_i == ADR_POOL_SIZE);

  assign stat_clr = wr_stat ? wdata_i[NSRC-1:0] : '0;
  assign en_set   = wr_set  ? wdata_i[NSRC-1:0] : '0;
  assign en_clr   = wr_clr  ? wdata_i[NSRC-1:0] : '0;

  // out-of-memory is fed as a level, the other two as pulses
  always_comb begin
    stat_set            = '0;
    stat_set[SRC_OOM]   = starved;
    stat_set[SRC_FLUSH] = flush_done_i;
    stat_set[SRC_FRAME] = frame_done_i;
  end

  gfx_irq_status #(.N(NSRC)) u_status (
    .clk_i, .rst_ni, .set_i(stat_set), .clr_i(stat_clr), .stat_o(stat));

  gfx_irq_mask #(.N(NSRC)) u_mask (
    .clk_i, .rst_ni, .set_i(en_set), .clr_i(en_clr), .mask_o(mask));

  gfx_irq_pool #(.W(DATA_W)) u_pool (
    .clk_i, .rst_ni, .wr_base_i(wr_base), .wr_size_i(wr_size),
    .wdata_i, .spent_i(pool_spent_i), .base_o(pool_base_o),
    .size_o(pool_size_o), .starved_o(starved));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(stat & mask);
  end
  assign irq_o     = irq_q;
  assign pool_ok_o = ~starved;

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        ADR_STATUS:             rdata_o = {{PAD_W{1'b0}}, stat};
        ADR_EN_SET, ADR_EN_CLR: rdata_o = {{PAD_W{1'b0}}, mask};
        ADR_POOL_BASE:          rdata_o = pool_base_o;
        ADR_POOL_SIZE:          rdata_o = pool_size_o;
        default:                rdata_o = '0;
      endcase
    end
  end

  assert_oom_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    starved |=> stat[SRC_OOM]);
  assert_irq_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat & mask) == '0) |=> !irq_o);
  assert_irq_fire_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat & mask) != '0) |=> irq_o);
  assert_rd_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> (rdata_o == '0));
endmodule

// File: tb/sim_gfx_irq_ctrl.sv
module sim_gfx_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        flush = 1'b0, frame = 1'b0, spent = 1'b0;
  logic [31:0] rdata, pbase, psize;
  logic        pok, irq;

  int checks = 0, errors = 0, cyc = 0;

  // bench model state
  logic [2:0]  m_stat, m_mask;
  logic [31:0] m_base, m_size;
  logic        m_starved, m_armed, m_irq;

  always #10 clk = ~clk;  // 50 MHz

  gfx_irq_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .flush_done_i(flush), .frame_done_i(frame), .pool_spent_i(spent),
    .pool_base_o(pbase), .pool_size_o(psize), .pool_ok_o(pok), .irq_o(irq));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(logic [2:0] a);
    case (a)
      3'd0:       return {29'b0, m_stat};
      3'd1, 3'd2: return {29'b0, m_mask};
      3'd3:       return m_base;
      3'd4:       return m_size;
      default:    return 32'h0;
    endcase
  endfunction

  task automatic model_reset();
    m_stat = '0; m_mask = '0; m_base = '0; m_size = '0;
    m_starved = 1'b1; m_armed = 1'b0; m_irq = 1'b0;
  endtask

  task automatic model_edge();
    logic [2:0] clr;
    logic       n_irq;
    n_irq = |(m_stat & m_mask);
    clr = (wr_en && addr == 3'd0) ? wdata[2:0] : 3'b0;
    m_stat[0] = m_starved | (m_stat[0] & ~clr[0]);
    m_stat[1] = flush     | (m_stat[1] & ~clr[1]);
    m_stat[2] = frame     | (m_stat[2] & ~clr[2]);
    if (wr_en && addr == 3'd1) m_mask = m_mask | wdata[2:0];
    if (wr_en && addr == 3'd2) m_mask = m_mask & ~wdata[2:0];
    if (wr_en && addr == 3'd3) begin m_base = wdata; m_armed = 1'b1; end
    if (wr_en && addr == 3'd4) begin
      m_size = wdata;
      if (m_armed && wdata != 0) m_starved = 1'b0;
      m_armed = 1'b0;
    end
    if (spent) begin m_starved = 1'b1; m_armed = 1'b0; end
    m_irq = n_irq;
  endtask

  // one bus cycle; inputs driven after negedge, checks before and after the edge
  task automatic step(logic w, logic r, logic [2:0] a, logic [31:0] d,
                      logic fl, logic fr, logic sp, string tag);
    wr_en = w; rd_en = r; addr = a; wdata = d; flush = fl; frame = fr; spent = sp;
    #1;
    chk({tag, " R4/R12 rdata"}, rdata, r ? exp_read(a) : 32'h0);
    @(posedge clk);
    model_edge();
    #1;
    chk({tag, " R8 irq"}, {31'b0, irq}, {31'b0, m_irq});
    chk({tag, " R7 pool_ok"}, {31'b0, pok}, {31'b0, ~m_starved});
    chk({tag, " R7 base"}, pbase, m_base);
    chk({tag, " R7 size"}, psize, m_size);
    @(negedge clk);
    wr_en = 0; rd_en = 0; flush = 0; frame = 0; spent = 0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d, string tag);
    step(1, 0, a, d, 0, 0, 0, tag);
  endtask

  task automatic rd_chk(logic [2:0] a, logic [31:0] exp, string tag);
    rd_en = 1; addr = a; #1;
    chk(tag, rdata, exp);
    rd_en = 0;
  endtask

  initial begin
    model_reset();
    @(negedge clk); @(negedge clk);
    // R11: state right after release, before any edge updates it
    rst_ni = 1'b1;
    rd_chk(3'd0, 32'h0, "R11 status zero at reset");
    rd_chk(3'd1, 32'h0, "R11 mask zero at reset");
    chk("R11 pool size zero", psize, 32'h0);
    chk("R11 starved at reset", {31'b0, pok}, 32'h0);
    chk("R11 irq low", {31'b0, irq}, 32'h0);
    step(0, 0, 0, 0, 0, 0, 0, "idle");
    rd_chk(3'd0, 32'h1, "R11 oom pending after first edge");

    // R6: clearing out-of-memory while starved comes back
    wr(3'd0, 32'h1, "clr oom");
    rd_chk(3'd0, 32'h1, "R6 oom reasserts");

    // R2/R3/R4 mask access through both addresses
    wr(3'd1, 32'h6, "en set");
    rd_chk(3'd1, 32'h6, "R4 mask via set addr");
    rd_chk(3'd2, 32'h6, "R4 mask via clr addr");
    wr(3'd2, 32'h2, "en clr");
    rd_chk(3'd2, 32'h4, "R3 clear bit1");
    wr(3'd1, 32'h0, "en set zeros");
    rd_chk(3'd1, 32'h4, "R2 zero bits ignored");

    // R8: frame event, irq one cycle after status
    step(0, 0, 0, 0, 0, 1, 0, "frame");
    rd_chk(3'd0, 32'h5, "R9 frame recorded");
    chk("R8 irq lags status", {31'b0, irq}, 32'h0);
    step(0, 0, 0, 0, 0, 0, 0, "idle");
    chk("R8 irq raised", {31'b0, irq}, 32'h1);

    // R1/R5: clear frame, stays clear
    wr(3'd0, 32'h4, "clr frame");
    step(0, 0, 0, 0, 0, 0, 0, "idle");
    step(0, 0, 0, 0, 0, 0, 0, "idle");
    rd_chk(3'd0, 32'h1, "R5 frame stays clear");
    chk("R8 irq dropped", {31'b0, irq}, 32'h0);

    // R9: masked flush still recorded, no irq
    step(0, 0, 0, 0, 1, 0, 0, "flush masked");
    step(0, 0, 0, 0, 0, 0, 0, "idle");
    rd_chk(3'd0, 32'h3, "R9 masked flush recorded");
    chk("R9 no irq when masked", {31'b0, irq}, 32'h0);

    // R10: event and clear together, event wins
    step(1, 0, 3'd0, 32'h2, 1, 0, 0, "collide");
    rd_chk(3'd0, 32'h3, "R10 event beats clear");
    wr(3'd0, 32'h2, "clr flush");
    rd_chk(3'd0, 32'h1, "R1 flush cleared");
    wr(3'd0, 32'h0, "zero w1c");
    rd_chk(3'd0, 32'h1, "R1 zero write keeps bit");

    // R7: pool sequencing
    wr(3'd4, 32'h100, "size w/o base");
    chk("R7 size without base stays starved", {31'b0, pok}, 32'h0);
    wr(3'd3, 32'h8000_0000, "base");
    wr(3'd4, 32'h0, "zero size");
    chk("R7 zero size stays starved", {31'b0, pok}, 32'h0);
    wr(3'd3, 32'h8000_1000, "base");
    wr(3'd4, 32'h4_0000, "good size");
    chk("R7 base then size fills", {31'b0, pok}, 32'h1);
    wr(3'd0, 32'h1, "clr oom");
    step(0, 0, 0, 0, 0, 0, 0, "idle");
    rd_chk(3'd0, 32'h0, "R6 oom stays clear once fed");
    step(0, 0, 0, 0, 0, 0, 1, "spent");
    chk("R7 spent starves", {31'b0, pok}, 32'h0);
    step(0, 0, 0, 0, 0, 0, 0, "idle");
    rd_chk(3'd0, 32'h1, "R6 oom back after spent");

    // R12: unmapped reads
    for (int a = 5; a < 8; a++) rd_chk(a[2:0], 32'h0, "R12 unmapped read");

    // constrained random against the model
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 3000; i++) begin
      logic       w, r, fl, fr, sp;
      logic [2:0] a;
      logic [31:0] d;
      w  = ($urandom % 3) == 0;
      r  = ($urandom % 2) == 0;
      a  = 3'($urandom % 8);
      d  = (($urandom % 4) == 0) ? 32'h0 : $urandom;
      fl = ($urandom % 5) == 0;
      fr = ($urandom % 5) == 0;
      sp = ($urandom % 40) == 0;
      step(w, r, a, d, fl, fr, sp, "random R1 R2 R3 R5 R6 R7 R9 R10");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule